// File: doc/BRIEF.md
# Debug System-Control Register Scan Chain

This block is a 40-bit test data register that sits behind a JTAG TAP controller. Through it, a debugger can read and write a small bank of system-control registers. The TAP drives three strobes into the block: capture, shift and update. Each strobe acts on the rising edge of TCK while the chain is selected. Serial data enters from TDI and leaves from TDO.

A frame has four fields. Bit 39 is the write flag: 1 means write and 0 means read. Bits 38:33 are a six-bit register address, laid out as bank select (bit 38), register number (bits 37:34) and sub-select (bit 33). Bits 32:1 hold 32 bits of data. Bit 0 is the mode bit, where 1 selects direct physical access.

A physical write takes effect at update. A physical read latches its address at update. The value is then loaded into the data field at the next capture and comes out during the shift that follows.

When bit 0 of the test-state register is set, a frame with mode bit 0 and an all-zero header is an interpreted frame. Its data field is handed to a separate execution path as an instruction word, together with a valid flag.

Top module: `dbg_sysreg_chain`

## Requirements
- R1: The chain is 40 bits long. Each shift moves TDI into bit 39 and every other bit one place down. TDO always shows bit 0, so a frame shifted in LSB first comes out unchanged 40 shifts later.
- R2: An update with bit 0 = 1 and bit 39 = 1 writes bits 32:1 into the addressed read/write register. The read/write registers are control (address 0x02), process ID (0x1A) and test state (0x1E).
- R3: An update with bit 0 = 1 and bit 39 = 0 latches a read. At the next capture, bits 32:1 are loaded with the addressed register's value.
- R4: Address 0x00 reads the ID constant and address 0x01 reads the cache-type constant. Both values are set by parameter, and a write to either address changes nothing.
- R5: Address 0x12 reads the data-cache lockdown input and address 0x13 reads the instruction-cache lockdown input. Both are read-only.
- R6: A write to an unmapped address changes no register. A read of an unmapped address returns zero.
- R7: While chain_sel is low, the capture, shift and update strobes have no effect.
- R8: Take a frame with bit 0 = 0, bits 39:33 all zero, and test-state bit 0 set. At its update, bits 32:1 appear on instr_out and instr_valid goes high from the following cycle.
- R9: An interpreted frame is ignored when test-state bit 0 is clear or when its header bits are non-zero. Clearing test-state bit 0 drops instr_valid.
- R10: After trst_n is asserted, the control, process-ID and test-state registers are zero and instr_valid is low.
- R11: A capture that does not follow a physical read update leaves the chain contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test-logic reset |
| chain_sel | input | 1 | This data register is selected by the TAP |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| dlock_in | input | 32 | Data-cache lockdown value |
| ilock_in | input | 32 | Instruction-cache lockdown value |
| ctrl_out | output | 32 | Control register |
| pid_out | output | 32 | Process-ID register |
| test_out | output | 32 | Test-state register, bit 0 enables interpreted mode |
| instr_out | output | 32 | Held instruction word |
| instr_valid | output | 1 | Instruction word valid |

## Verification
The assertions check on every cycle that:
- each shift moves bit 1 to TDO;
- the control register takes the written data at update, and a physical write to a read-only or unmapped address leaves the writable registers alone;
- no register moves without a selected update;
- instr_valid rises only at an accepted interpreted update.

Only the bench scenarios can show:
- the two-pass read sequence;
- the constant and lockdown read values and the zero returned for unmapped reads;
- the pass-through of capture after a write;
- the read-modify-write of the interpret enable;
- the reset state.

These bench checks compare scanned-out frames against a register model.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int CHAIN_W = 40;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int NUM_RW  = 3;

  localparam logic [ADDR_W-1:0] A_ID    = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTYPE = 6'h01;
  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h02;
  localparam logic [ADDR_W-1:0] A_DLOCK = 6'h12;
  localparam logic [ADDR_W-1:0] A_ILOCK = 6'h13;
  localparam logic [ADDR_W-1:0] A_PID   = 6'h1A;
  localparam logic [ADDR_W-1:0] A_TEST  = 6'h1E;

  localparam logic [ADDR_W-1:0] RW_ADDR [NUM_RW] = '{A_CTRL, A_PID, A_TEST};

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              phys;
  } frame_t;
endpackage

// File: rtl/dbgc_rst_sync.sv
module dbgc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dbgc_shifter.sv
module dbgc_shifter
  import dbgc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               cap_en,
  input  logic [DATA_W-1:0]  cap_data,
  input  logic               sdi,
  output logic [CHAIN_W-1:0] frame_q,
  output logic               sdo
);
  logic [CHAIN_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) begin
      frame_d = {sdi, frame_q[CHAIN_W-1:1]};
    end else if (cap_en) begin
      frame_d[DATA_W:1] = cap_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  frame_q <= '0;
    else if (shift_en || cap_en) frame_q <= frame_d;
  end

  assign sdo = frame_q[0];
endmodule

// File: rtl/dbgc_regbank.sv
module dbgc_regbank
  import dbgc_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h1357_2468,
  parameter logic [31:0] CTYPE_VALUE = 32'h0D17_2A51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] dlock_in,
  input  logic [DATA_W-1:0] ilock_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] pid_q,
  output logic [DATA_W-1:0] test_q
);
  logic [DATA_W-1:0] rw_q [NUM_RW];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    logic hit;
    assign hit = wr_en && (wr_addr == RW_ADDR[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rw_q[g] <= '0;
      else if (hit) rw_q[g] <= wr_data;
    end
  end

  assign ctrl_q = rw_q[0];
  assign pid_q  = rw_q[1];
  assign test_q = rw_q[2];

  always_comb begin
    case (rd_addr)
      A_ID:    rd_data = ID_VALUE;
      A_CTYPE: rd_data = CTYPE_VALUE;
      A_CTRL:  rd_data = rw_q[0];
      A_PID:   rd_data = rw_q[1];
      A_TEST:  rd_data = rw_q[2];
      A_DLOCK: rd_data = dlock_in;
      A_ILOCK: rd_data = ilock_in;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dbgc_interp.sv
module dbgc_interp
  import dbgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic [DATA_W-1:0] instr_in,
  output logic [DATA_W-1:0] instr_q,
  output logic              valid
);
  logic [DATA_W-1:0] instr_d;
  logic              valid_q, valid_d;
  logic              instr_en;

  always_comb begin
    instr_en = enable && load;
    instr_d  = instr_in;
    valid_d  = valid_q;
    if (!enable)   valid_d = 1'b0;
    else if (load) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        instr_q <= '0;
    else if (instr_en) instr_q <= instr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign valid = valid_q && enable;
endmodule

// File: rtl/dbg_sysreg_chain.sv
module dbg_sysreg_chain
  import dbgc_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h1357_2468,
  parameter logic [31:0] CTYPE_VALUE = 32'h0D17_2A51,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        tck,
  input  logic        trst_n,
  input  logic        chain_sel,
  input  logic        capture_dr,
  input  logic        shift_dr,
  input  logic        update_dr,
  input  logic        tdi,
  output logic        tdo,
  input  logic [31:0] dlock_in,
  input  logic [31:0] ilock_in,
  output logic [31:0] ctrl_out,
  output logic [31:0] pid_out,
  output logic [31:0] test_out,
  output logic [31:0] instr_out,
  output logic        instr_valid
);
  logic               rst_n;
  logic [CHAIN_W-1:0] frame_q;
  frame_t             fr;
  logic               upd, shift_en, cap_en;
  logic               rd_pend_q, rd_pend_d;
  logic [ADDR_W-1:0]  rd_addr_q, rd_addr_d;
  logic [DATA_W-1:0]  rd_data;
  logic               wr_en, interp_load;

  dbgc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_n)
  );

  assign fr       = frame_q;
  assign upd      = chain_sel && update_dr;
  assign shift_en = chain_sel && shift_dr;
  assign cap_en   = chain_sel && capture_dr && rd_pend_q;

  // update-time decode
  always_comb begin
    wr_en       = upd && fr.phys && fr.wr;
    interp_load = upd && !fr.phys && !fr.wr && (fr.addr == '0);
    rd_pend_d   = rd_pend_q;
    rd_addr_d   = rd_addr_q;
    if (upd) begin
      rd_pend_d = fr.phys && !fr.wr;
      if (fr.phys && !fr.wr) rd_addr_d = fr.addr;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else if (upd) begin
      rd_pend_q <= rd_pend_d;
      rd_addr_q <= rd_addr_d;
    end
  end

  dbgc_shifter u_shift (
    .clk(tck), .rst_n(rst_n), .shift_en(shift_en), .cap_en(cap_en),
    .cap_data(rd_data), .sdi(tdi), .frame_q(frame_q), .sdo(tdo)
  );

  dbgc_regbank #(.ID_VALUE(ID_VALUE), .CTYPE_VALUE(CTYPE_VALUE)) u_regs (
    .clk(tck), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(fr.addr),
    .wr_data(fr.data), .rd_addr(rd_addr_q), .dlock_in(dlock_in),
    .ilock_in(ilock_in), .rd_data(rd_data), .ctrl_q(ctrl_out),
    .pid_q(pid_out), .test_q(test_out)
  );

  dbgc_interp u_interp (
    .clk(tck), .rst_n(rst_n), .enable(test_out[0]), .load(interp_load),
    .instr_in(fr.data), .instr_q(instr_out), .valid(instr_valid)
  );
endmodule

// File: rtl/dbgc_checker.sv
module dbgc_checker (
  input logic        tck,
  input logic        rst_n,
  input logic        chain_sel,
  input logic        update_dr,
  input logic        shift_dr,
  input logic        tdo,
  input logic [39:0] frame_q,
  input logic [31:0] ctrl_out,
  input logic [31:0] pid_out,
  input logic [31:0] test_out,
  input logic [31:0] instr_out,
  input logic        instr_valid
);
  logic phys_wr, rw_hit, interp_ok;
  assign phys_wr   = chain_sel && update_dr && frame_q[0] && frame_q[39];
  assign rw_hit    = (frame_q[38:33] == 6'h02) || (frame_q[38:33] == 6'h1A)
                  || (frame_q[38:33] == 6'h1E);
  assign interp_ok = chain_sel && update_dr && !frame_q[0]
                  && (frame_q[39:33] == 7'd0) && test_out[0];

  assert_shift_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (chain_sel && shift_dr) |=> (tdo == $past(frame_q[1])));

  assert_ctrl_write_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (phys_wr && frame_q[38:33] == 6'h02) |=> (ctrl_out == $past(frame_q[32:1])));

  assert_ro_write_ignored_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (phys_wr && !rw_hit) |=> ($stable(ctrl_out) && $stable(pid_out) && $stable(test_out)));

  assert_no_update_no_change_R7: assert property (@(posedge tck) disable iff (!rst_n)
    !(chain_sel && update_dr) |=> ($stable(ctrl_out) && $stable(pid_out) && $stable(test_out)));

  assert_interp_load_R8: assert property (@(posedge tck) disable iff (!rst_n)
    interp_ok |=> (instr_valid && instr_out == $past(frame_q[32:1])));

  assert_valid_rise_R8: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(instr_valid) |-> $past(chain_sel && update_dr));

  assert_interp_disabled_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (chain_sel && update_dr && !frame_q[0] && !test_out[0]) |=> !instr_valid);
endmodule

bind dbg_sysreg_chain dbgc_checker u_chk (
  .tck(tck), .rst_n(rst_n), .chain_sel(chain_sel), .update_dr(update_dr),
  .shift_dr(shift_dr), .tdo(tdo), .frame_q(frame_q), .ctrl_out(ctrl_out),
  .pid_out(pid_out), .test_out(test_out), .instr_out(instr_out),
  .instr_valid(instr_valid)
);

// File: tb/dbg_sysreg_chain_test.sv
module dbg_sysreg_chain_test;
  localparam logic [31:0] IDV = 32'h1357_2468;
  localparam logic [31:0] CTV = 32'h0D17_2A51;
  localparam logic [31:0] DLK = 32'hA5A5_0003;
  localparam logic [31:0] ILK = 32'h5A5A_0001;

  logic tck = 1'b0;
  logic trst_n, chain_sel, capture_dr, shift_dr, update_dr, tdi, tdo;
  logic [31:0] ctrl_out, pid_out, test_out, instr_out;
  logic instr_valid;
  int n_tests = 0, n_fail = 0;
  logic [31:0] m_ctrl, m_pid, m_test;

  always #4 tck = ~tck;

  dbg_sysreg_chain #(.ID_VALUE(IDV), .CTYPE_VALUE(CTV)) uut (
    .tck(tck), .trst_n(trst_n), .chain_sel(chain_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .dlock_in(DLK), .ilock_in(ILK), .ctrl_out(ctrl_out), .pid_out(pid_out),
    .test_out(test_out), .instr_out(instr_out), .instr_valid(instr_valid)
  );

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    case (a)
      6'h00: return IDV;
      6'h01: return CTV;
      6'h02: return m_ctrl;
      6'h12: return DLK;
      6'h13: return ILK;
      6'h1A: return m_pid;
      6'h1E: return m_test;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [39:0] mk(input logic w, input logic [5:0] a,
                                     input logic [31:0] d, input logic p);
    return {w, a, d, p};
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic scan(input logic [39:0] din, output logic [39:0] dout);
    for (int i = 0; i < 40; i++) begin
      @(negedge tck);
      dout[i]  = tdo;
      tdi      = din[i];
      shift_dr = 1'b1;
    end
    @(negedge tck);
    shift_dr = 1'b0;
  endtask

  task automatic pulse_update();
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
  endtask

  task automatic pulse_capture();
    capture_dr = 1'b1;
    @(negedge tck);
    capture_dr = 1'b0;
  endtask

  task automatic phys_write(input logic [5:0] a, input logic [31:0] d);
    logic [39:0] junk;
    scan(mk(1'b1, a, d, 1'b1), junk);
    pulse_update();
    if (a == 6'h02) m_ctrl = d;
    if (a == 6'h1A) m_pid  = d;
    if (a == 6'h1E) m_test = d;
  endtask

  task automatic phys_read(input logic [5:0] a, output logic [31:0] d);
    logic [39:0] junk, got;
    scan(mk(1'b0, a, 32'h0, 1'b1), junk);
    pulse_update();
    pulse_capture();
    scan(40'h0, got);
    d = got[32:1];
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [39:0] got, junk;
    logic [5:0] alist [8];
    alist = '{6'h00, 6'h01, 6'h02, 6'h12, 6'h13, 6'h1A, 6'h1E, 6'h2B};
    void'($urandom(32'h00C0_FFEE));
    trst_n = 1'b0; chain_sel = 1'b1; capture_dr = 1'b0; shift_dr = 1'b0;
    update_dr = 1'b0; tdi = 1'b0;
    m_ctrl = '0; m_pid = '0; m_test = '0;
    repeat (4) @(negedge tck);
    trst_n = 1'b1;
    repeat (4) @(negedge tck);

    // R10 reset state
    check("R10 ctrl", {8'h0, ctrl_out}, 40'h0);
    check("R10 pid",  {8'h0, pid_out},  40'h0);
    check("R10 test", {8'h0, test_out}, 40'h0);
    check("R10 valid", {39'h0, instr_valid}, 40'h0);

    // R1 shift-through
    scan(40'hA5_1234_5678, junk);
    scan(40'h0, got);
    check("R1 passthrough", got, 40'hA5_1234_5678);

    // R2 / R3 write and read back
    phys_write(6'h02, 32'hDEAD_BEEF);
    check("R2 ctrl port", {8'h0, ctrl_out}, {8'h0, 32'hDEAD_BEEF});
    phys_read(6'h02, rd);
    check("R3 ctrl read", {8'h0, rd}, {8'h0, 32'hDEAD_BEEF});
    phys_write(6'h1A, 32'h0000_00A7);
    phys_read(6'h1A, rd);
    check("R3 pid read", {8'h0, rd}, {8'h0, 32'h0000_00A7});

    // R4 constants, writes ignored
    phys_write(6'h00, 32'hFFFF_FFFF);
    phys_read(6'h00, rd);
    check("R4 id", {8'h0, rd}, {8'h0, IDV});
    phys_write(6'h01, 32'h1111_1111);
    phys_read(6'h01, rd);
    check("R4 ctype", {8'h0, rd}, {8'h0, CTV});

    // R5 lockdown inputs
    phys_write(6'h12, 32'h0);
    phys_read(6'h12, rd);
    check("R5 dlock", {8'h0, rd}, {8'h0, DLK});
    phys_read(6'h13, rd);
    check("R5 ilock", {8'h0, rd}, {8'h0, ILK});

    // R6 unmapped
    phys_write(6'h3F, 32'h7777_7777);
    check("R6 ctrl untouched", {8'h0, ctrl_out}, {8'h0, m_ctrl});
    check("R6 pid untouched", {8'h0, pid_out}, {8'h0, m_pid});
    phys_read(6'h3F, rd);
    check("R6 unmapped read", {8'h0, rd}, 40'h0);

    // R11 capture after write leaves chain as is
    scan(mk(1'b1, 6'h1A, 32'h0BAD_F00D, 1'b1), junk);
    pulse_update(); m_pid = 32'h0BAD_F00D;
    pulse_capture();
    scan(40'h0, got);
    check("R11 capture no-op", got, mk(1'b1, 6'h1A, 32'h0BAD_F00D, 1'b1));

    // R7 deselected strobes
    chain_sel = 1'b0;
    scan(mk(1'b1, 6'h02, 32'h1234_0000, 1'b1), junk);
    pulse_update();
    pulse_capture();
    chain_sel = 1'b1;
    check("R7 ctrl unchanged", {8'h0, ctrl_out}, {8'h0, m_ctrl});
    phys_read(6'h02, rd);
    check("R7 ctrl read", {8'h0, rd}, {8'h0, m_ctrl});

    // R9 interpreted while disabled
    scan(mk(1'b0, 6'h00, 32'hE000_0001, 1'b0), junk);
    pulse_update();
    check("R9 disabled valid", {39'h0, instr_valid}, 40'h0);

    // R8 enable via read-modify-write, then interpreted frame
    phys_read(6'h1E, rd);
    phys_write(6'h1E, rd | 32'h1);
    scan(mk(1'b0, 6'h00, 32'hEE15_0F30, 1'b0), junk);
    pulse_update();
    check("R8 valid", {39'h0, instr_valid}, 40'h1);
    check("R8 instr", {8'h0, instr_out}, {8'h0, 32'hEE15_0F30});

    // R9 bad header ignored
    scan(mk(1'b0, 6'h04, 32'h1111_2222, 1'b0), junk);
    pulse_update();
    check("R9 bad header instr", {8'h0, instr_out}, {8'h0, 32'hEE15_0F30});
    check("R9 bad header valid", {39'h0, instr_valid}, 40'h1);

    // R9 clearing enable drops valid
    phys_read(6'h1E, rd);
    phys_write(6'h1E, rd & ~32'h1);
    @(negedge tck);
    check("R9 cleared valid", {39'h0, instr_valid}, 40'h0);

    // R2 R3 R6 random traffic against model
    for (int k = 0; k < 30; k++) begin
      logic [5:0] wa, ra;
      logic [31:0] wd;
      wa = alist[$urandom % 8];
      ra = alist[$urandom % 8];
      wd = $urandom;
      if (wa == 6'h1E) wd[0] = 1'b0;
      phys_write(wa, wd);
      phys_read(ra, rd);
      check("R3 random read", {2'b0, ra, rd}, {2'b0, ra, exp_read(ra)});
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule